// File: doc/BRIEF.md
# Power-On Reset and Clock Release Sequencer

This block decides when each part of the device may leave reset once the external reset input has gone inactive. It walks through six fixed phases in order: device hold, clock settling, a two-part memory initialization, main-clock start-up and finally run. Every phase length is a count of cycles of a free-running reference clock. The outputs follow a fixed pattern for each phase. The memory-busy line is raised only while the memory initializes, and it also serves to keep a debugger off the test port during that time. The main clock is enabled for a whole phase before the CPU and peripheral resets are released.

The memory may shorten its own initialization by pulsing a done input. After the start-up phase begins, a debug-permit output tells an external debugger that it may start its halt handshake. This is the window after memory initialization and before any code runs. The oscillator, the memory array and the clock gating cell are outside this block; it produces only enables and resets.

Top module: `por_seq`

## Requirements
- R1: While `rst_in_n` is low, the block is in phase 1 (`phase_o` = 1), with `cpu_rst_n`, `per_rst_n`, `mclk_en`, `mem_busy` and `debug_allowed` all 0. A low level takes effect at once, without waiting for a clock edge.
- R2: The release of `rst_in_n` passes through a synchronizer of `SYNC_STAGES` flops (default 2). With two stages, `phase_o` shows 2 from the third rising edge after the release.
- R3: Phase 2 (clock settling) lasts exactly `STAB_CYC` reference cycles (default 255), with every output inactive.
- R4: Memory initialization is phase 3 for `INIT_A_CYC` cycles followed by phase 4 for `INIT_B_CYC` cycles (defaults 1024 + 1024 = 2048). `mem_busy` is 1 in phases 3 and 4 and in no other phase.
- R5: A one-cycle pulse on `mem_done_i`, seen at a rising edge while in phase 3 or 4, moves the block to phase 5 at that edge.
- R6: A pulse on `mem_done_i` in any phase other than 3 or 4 has no effect, and the phase lengths stay as stated.
- R7: Phase 5 (clock start-up) lasts exactly `START_CYC` cycles (default 16), with `mclk_en` = 1 while `cpu_rst_n` and `per_rst_n` stay 0.
- R8: Phase 6 (run) is kept until the next reset, with `cpu_rst_n` = 1, `per_rst_n` = 1 and `mclk_en` = 1.
- R9: `debug_allowed` is 1 in phases 5 and 6 and 0 in phases 1 to 4.
- R10: `phase_o` holds only the values 1 to 6. It changes only to the next value, or from 3 straight to 5.
- R11: Pulling `rst_in_n` low in any phase returns the block to phase 1 and clears the phase counter. After the next release, the whole sequence runs again with full phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock that times every phase |
| rst_in_n | input | 1 | Asynchronous active-low device reset input |
| mem_done_i | input | 1 | One-cycle early-completion pulse from the memory, synchronous to `clk_ref` |
| cpu_rst_n | output | 1 | Active-low CPU reset |
| per_rst_n | output | 1 | Active-low peripheral reset |
| mclk_en | output | 1 | Enable for the main clock gate |
| mem_busy | output | 1 | Memory initialization in progress; also blocks debug access |
| debug_allowed | output | 1 | An external debugger may begin its handshake |
| phase_o | output | 3 | Current phase, 1 to 6 |

## Verification
The bench builds the sequencer with `STAB_CYC` = 5, `INIT_A_CYC` = 6, `INIT_B_CYC` = 4 and `START_CYC` = 3, and keeps the default two-stage synchronizer. With phases this short, a complete release-to-run walk takes a few dozen cycles. The bench can therefore repeat it many times: with an early-done pulse landing in each memory phase, with pulses landing outside them, and with a reset in the middle of the sequence followed by a full second pass. At these sizes a length that is off by one cycle, or an early exit taken from the wrong phase, shows up directly as a wrong phase count.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

   typedef enum logic [2:0] {
      PH_HOLD   = 3'd1,
      PH_STAB   = 3'd2,
      PH_INIT_A = 3'd3,
      PH_INIT_B = 3'd4,
      PH_CLKUP  = 3'd5,
      PH_RUN    = 3'd6
   } phase_e;

   typedef struct packed {
      logic busy;
      logic cpu_rst_n;
      logic per_rst_n;
      logic mclk_en;
      logic dbg_ok;
   } ctl_s;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rel
);
   logic [STAGES-1:0] q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rseq_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) q <= '0;
      else         q <= {q[STAGES-2:0], 1'b1};
   end

   assign rel = q[STAGES-1];
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          clr,
   input  logic [CW-1:0] lim,
   output logic          tc
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)  cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   assign tc = (cnt_q == lim);
endmodule

// File: rtl/rseq_decode.sv
module rseq_decode
   import rseq_pkg::*;
(
   input  phase_e ph,
   output ctl_s   ctl
);
   always_comb begin
      ctl = '0;
      unique case (ph)
         PH_INIT_A, PH_INIT_B: ctl.busy = 1'b1;
         PH_CLKUP: begin
            ctl.mclk_en = 1'b1;
            ctl.dbg_ok  = 1'b1;
         end
         PH_RUN: begin
            ctl.mclk_en   = 1'b1;
            ctl.dbg_ok    = 1'b1;
            ctl.cpu_rst_n = 1'b1;
            ctl.per_rst_n = 1'b1;
         end
         default: ctl = '0;
      endcase
   end
endmodule

// File: rtl/por_seq.sv
module por_seq
   import rseq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STAB_CYC    = 255,
   parameter int INIT_A_CYC  = 1024,
   parameter int INIT_B_CYC  = 1024,
   parameter int START_CYC   = 16
) (
   input  logic       clk_ref,
   input  logic       rst_in_n,
   input  logic       mem_done_i,
   output logic       cpu_rst_n,
   output logic       per_rst_n,
   output logic       mclk_en,
   output logic       mem_busy,
   output logic       debug_allowed,
   output logic [2:0] phase_o
);
   localparam int MAXLEN = max2(max2(STAB_CYC, START_CYC), max2(INIT_A_CYC, INIT_B_CYC));
   localparam int CW     = max2(1, $clog2(MAXLEN));
   localparam logic [CW-1:0] LIM_STAB  = CW'(STAB_CYC - 1);
   localparam logic [CW-1:0] LIM_INITA = CW'(INIT_A_CYC - 1);
   localparam logic [CW-1:0] LIM_INITB = CW'(INIT_B_CYC - 1);
   localparam logic [CW-1:0] LIM_START = CW'(START_CYC - 1);

   generate
      if (STAB_CYC < 1 || INIT_A_CYC < 1 || INIT_B_CYC < 1 || START_CYC < 1) begin : g_bad_len
         $error("por_seq: every phase length must be at least one cycle");
      end
   endgenerate

   phase_e        phase_q, phase_d;
   logic          rel_s;
   logic          tc_s;
   logic          clr_s;
   logic [CW-1:0] lim_s;
   ctl_s          ctl_s_w;

   rseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk_ref),
      .arst_n (rst_in_n),
      .rel    (rel_s)
   );

   always_comb begin
      unique case (phase_q)
         PH_STAB:   lim_s = LIM_STAB;
         PH_INIT_A: lim_s = LIM_INITA;
         PH_INIT_B: lim_s = LIM_INITB;
         PH_CLKUP:  lim_s = LIM_START;
         default:   lim_s = '0;
      endcase
   end

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_HOLD:   if (rel_s) phase_d = PH_STAB;
         PH_STAB:   if (tc_s)  phase_d = PH_INIT_A;
         PH_INIT_A: begin
            if (mem_done_i) phase_d = PH_CLKUP;
            else if (tc_s)  phase_d = PH_INIT_B;
         end
         PH_INIT_B: if (mem_done_i || tc_s) phase_d = PH_CLKUP;
         PH_CLKUP:  if (tc_s)  phase_d = PH_RUN;
         PH_RUN:    phase_d = PH_RUN;
         default:   phase_d = PH_HOLD;
      endcase
   end

   assign clr_s = (phase_d != phase_q) || (phase_q == PH_HOLD) || (phase_q == PH_RUN);

   rseq_timer #(.CW(CW)) u_timer (
      .clk    (clk_ref),
      .arst_n (rst_in_n),
      .clr    (clr_s),
      .lim    (lim_s),
      .tc     (tc_s)
   );

   always_ff @(posedge clk_ref or negedge rst_in_n) begin
      if (!rst_in_n) phase_q <= PH_HOLD;
      else           phase_q <= phase_d;
   end

   rseq_decode u_dec (
      .ph  (phase_q),
      .ctl (ctl_s_w)
   );

   assign mem_busy      = ctl_s_w.busy;
   assign cpu_rst_n     = ctl_s_w.cpu_rst_n;
   assign per_rst_n     = ctl_s_w.per_rst_n;
   assign mclk_en       = ctl_s_w.mclk_en;
   assign debug_allowed = ctl_s_w.dbg_ok;
   assign phase_o       = phase_q;
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk #(
   parameter int STAB_CYC  = 255,
   parameter int START_CYC = 16
) (
   input logic       clk_ref,
   input logic       rst_in_n,
   input logic       cpu_rst_n,
   input logic       per_rst_n,
   input logic       mclk_en,
   input logic       mem_busy,
   input logic       debug_allowed,
   input logic [2:0] phase_o
);
   logic [2:0]  last_ph_q;
   logic [31:0] run_q;

   always_ff @(posedge clk_ref or negedge rst_in_n) begin
      if (!rst_in_n) begin
         last_ph_q <= 3'd1;
         run_q     <= '0;
      end else begin
         last_ph_q <= phase_o;
         run_q     <= (phase_o == last_ph_q) ? run_q + 1 : 32'd1;
      end
   end

   AST_PHASE_LEGAL: assert property (@(posedge clk_ref) disable iff (!rst_in_n)
      (phase_o >= 3'd1 && phase_o <= 3'd6)); // R10
   AST_PHASE_STEP: assert property (@(posedge clk_ref) disable iff (!rst_in_n)
      (phase_o != $past(phase_o)) |->
      ((phase_o == $past(phase_o) + 3'd1) || ($past(phase_o) == 3'd3 && phase_o == 3'd5))); // R10
   AST_STAB_LEN: assert property (@(posedge clk_ref) disable iff (!rst_in_n)
      (last_ph_q == 3'd2 && phase_o != 3'd2) |-> (run_q == 32'(STAB_CYC))); // R3
   AST_BUSY_INIT_ONLY: assert property (@(posedge clk_ref) disable iff (!rst_in_n)
      mem_busy |-> (phase_o == 3'd3 || phase_o == 3'd4)); // R4
   AST_CLKUP_LEN: assert property (@(posedge clk_ref) disable iff (!rst_in_n)
      (last_ph_q == 3'd5 && phase_o != 3'd5) |-> (run_q == 32'(START_CYC))); // R7
   AST_CLK_BEFORE_RST: assert property (@(posedge clk_ref) disable iff (!rst_in_n)
      (cpu_rst_n || per_rst_n) |-> mclk_en); // R7
   AST_RUN_STICKY: assert property (@(posedge clk_ref) disable iff (!rst_in_n)
      (phase_o == 3'd6) |=> (phase_o == 3'd6)); // R8
   AST_RUN_RELEASED: assert property (@(posedge clk_ref) disable iff (!rst_in_n)
      (phase_o == 3'd6) |-> (cpu_rst_n && per_rst_n && mclk_en)); // R8
   AST_DBG_WINDOW: assert property (@(posedge clk_ref) disable iff (!rst_in_n)
      debug_allowed |-> (phase_o >= 3'd5 && !mem_busy)); // R9
endmodule

bind por_seq por_seq_chk #(.STAB_CYC(STAB_CYC), .START_CYC(START_CYC)) u_chk (
   .clk_ref       (clk_ref),
   .rst_in_n      (rst_in_n),
   .cpu_rst_n     (cpu_rst_n),
   .per_rst_n     (per_rst_n),
   .mclk_en       (mclk_en),
   .mem_busy      (mem_busy),
   .debug_allowed (debug_allowed),
   .phase_o       (phase_o)
);

// File: tb/por_seq_tb.sv
module por_seq_tb;
   localparam int CLK_P = 10;
   localparam int STAB  = 5;
   localparam int INA   = 6;
   localparam int INB   = 4;
   localparam int STRT  = 3;

   logic       clk = 1'b0;
   logic       rst_in_n = 1'b0;
   logic       mem_done = 1'b0;
   logic       cpu_rst_n, per_rst_n, mclk_en, mem_busy, debug_allowed;
   logic [2:0] phase_o;
   int         n_run = 0;
   int         n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   por_seq #(
      .SYNC_STAGES (2),
      .STAB_CYC    (STAB),
      .INIT_A_CYC  (INA),
      .INIT_B_CYC  (INB),
      .START_CYC   (STRT)
   ) u_dut (
      .clk_ref       (clk),
      .rst_in_n      (rst_in_n),
      .mem_done_i    (mem_done),
      .cpu_rst_n     (cpu_rst_n),
      .per_rst_n     (per_rst_n),
      .mclk_en       (mclk_en),
      .mem_busy      (mem_busy),
      .debug_allowed (debug_allowed),
      .phase_o       (phase_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_reset_outs(input string req);
      chk({req, " phase"}, phase_o, 1);
      chk({req, " outputs {cpu,per,mclk,busy,dbg}"},
          {cpu_rst_n, per_rst_n, mclk_en, mem_busy, debug_allowed}, 0);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_in_n = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // Releases reset at the current falling edge and walks to run phase.
   // inj selects the phase in which one mem_done pulse is placed (0: none).
   task automatic run_seq(input string tag, input int inj);
      int len[1:7];
      int prev, ph, six, injected;
      int bad_busy, bad_rst, bad_dbg, bad_tr;
      int e3, e4;
      e3 = (inj == 3) ? 1 : INA;
      e4 = (inj == 3) ? 0 : ((inj == 4) ? 1 : INB);
      foreach (len[i]) len[i] = 0;
      prev = 1; six = 0; injected = 0;
      bad_busy = 0; bad_rst = 0; bad_dbg = 0; bad_tr = 0;
      rst_in_n = 1'b1;
      for (int k = 0; k < 500 && six < 8; k++) begin
         @(negedge clk);
         mem_done = 1'b0;
         ph = int'(phase_o);
         if (ph >= 1 && ph <= 6) len[ph]++; else len[7]++;
         if (mem_busy != (ph == 3 || ph == 4)) bad_busy++;
         if ((mclk_en != (ph >= 5)) || (cpu_rst_n != (ph == 6)) || (per_rst_n != (ph == 6))) bad_rst++;
         if (debug_allowed != (ph >= 5)) bad_dbg++;
         if (!(ph == prev || ph == prev + 1 || (prev == 3 && ph == 5))) bad_tr++;
         prev = ph;
         if (ph == inj && injected == 0) begin
            mem_done = 1'b1;
            injected = 1;
         end
         if (ph == 6) six++;
      end
      mem_done = 1'b0;
      chk({tag, " R2 cycles in phase 1 after release"}, len[1], 2);
      chk({tag, " R3 phase 2 length"}, len[2], STAB);
      chk({tag, " R4 phase 3 length"}, len[3], e3);
      chk({tag, " R4 phase 4 length"}, len[4], e4);
      chk({tag, " R7 phase 5 length"}, len[5], STRT);
      chk({tag, " R8 run phase held"}, len[6], 8);
      chk({tag, " R10 out-of-range phase samples"}, len[7], 0);
      chk({tag, " R4 busy pattern errors"}, bad_busy, 0);
      chk({tag, " R7,R8 clock/reset pattern errors"}, bad_rst, 0);
      chk({tag, " R9 debug permit errors"}, bad_dbg, 0);
      chk({tag, " R10 illegal transitions"}, bad_tr, 0);
   endtask

   task automatic t_reset_state;
      rst_in_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_reset_outs("R1 held reset");
   endtask

   task automatic t_full_walk;
      run_seq("full", 0);
   endtask

   task automatic t_early_done;
      do_reset();
      run_seq("R5 done in phase 3", 3);
      do_reset();
      run_seq("R5 done in phase 4", 4);
   endtask

   task automatic t_done_ignored;
      do_reset();
      run_seq("R6 done in phase 2", 2);
      do_reset();
      run_seq("R6 done in phase 5", 5);
      do_reset();
      run_seq("R6 done in phase 6", 6);
   endtask

   task automatic t_mid_reset;
      do_reset();
      rst_in_n = 1'b1;
      for (int k = 0; k < 100 && phase_o != 3'd4; k++) @(negedge clk);
      chk("R11 reached phase 4 before abort", phase_o, 4);
      #2 rst_in_n = 1'b0;
      #1 chk_reset_outs("R11 async return");
      chk_reset_outs("R1 async return");
      @(negedge clk);
      run_seq("R11 rerun", 0);
   endtask

   initial begin
      #(CLK_P * 20000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset_state();
      t_full_walk();
      t_early_done();
      t_done_ignored();
      t_mid_reset();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule